// File: doc/BRIEF.md
# Flash Status Word Generator

This block builds the 8-bit word that a NOR flash part presents on its data pins while its embedded write/erase engine is active, while an erase is suspended, or after an operation has failed. When no status is due it passes the array data through unchanged. It also drives the ready/busy level. The array, the operation timing and the command decoder sit outside the block. A controller tells the block which operation is under way. The address decoder tells it whether the current read falls inside a block that is selected for erase, and whether that block failed to erase.

Two toggle flops are kept apart. The busy toggle on bit 6 follows every completed read at any address. The block toggle on bit 2 follows only reads inside erase-selected blocks. Both flops advance on the trailing edge of the read strobe. A sticky failure flag keeps the status word on the bus until a clear request arrives. It records whether the failed operation was a program or an erase, and the data bit that the program was writing.

Top module: `flash_status_gen`

## Requirements
- R1: After reset, with the operation state at 0 (read), the output equals the array data, ready/busy is 1 and both toggle bits start at 0.
- R2: The operation state is encoded as 0 read, 1 auto-select, 2 program, 3 chip erase, 4 block erase with the selection window open, 5 block erase running and 6 erase suspended. In state 2, bit 7 is the inverse of the program data bit 7. In states 3, 4 and 5, bit 7 is 0.
- R3: Bit 6 inverts after every completed read (falling edge of the read strobe) in states 2 to 5, whatever the block-hit flag. It does not change in state 6.
- R4: Bit 2 inverts after a completed read only when the block-hit flag was 1 during the read, and only in states 3 to 6. It holds on all other reads, including every read in state 2.
- R5: Bit 3 is 0 in state 4 and in state 2. It is 1 in states 3 and 5.
- R6: A failure pulse in state 2, 3 or 5 sets bit 5. Bit 5 stays set, and the status word stays on the output, until a clear pulse arrives, whatever the operation state. A failure pulse in any other state has no effect.
- R7: In state 6, a read with the block-hit flag at 1 returns bit 7 = 1, bit 3 = 0, a static bit 6 and a toggling bit 2. A read with the block-hit flag at 0 returns the array data.
- R8: After a failed erase, bit 7 is 0 and bit 3 is 1. Bit 6 keeps toggling on every read. Bit 2 toggles only on reads whose block-fail flag is 1. After a failed program, bit 7 is the inverse of the program data bit 7 captured when the failure occurred.
- R9: Ready/busy is 0 in states 2 to 5 and 1 in states 0, 1 and 6.
- R10: Entering state 2, 3 or 4 from a different state clears both toggle bits. Moving from state 4 to 5, or from 6 back to 5, keeps them.
- R11: In the status word, bits 4, 1 and 0 are always 0.
- R12: In states 0 and 1, with no failure pending, the output is the array data. A pending failure takes priority over the operation state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| opState | input | 3 | Operation state code (see R2) |
| rdStrobe | input | 1 | Read in progress; its falling edge completes a read |
| blockHit | input | 1 | Read address lies in a block selected for erase |
| blockFail | input | 1 | Read address lies in a block that failed to erase |
| progBit7 | input | 1 | Bit 7 of the word being programmed |
| opFail | input | 1 | One-cycle pulse reporting a failed program or erase |
| clrErr | input | 1 | One-cycle pulse from the reset command, clears the failure |
| arrayData | input | DATA_W | Data read from the array |
| statusOut | output | DATA_W | Word presented on the data pins |
| rdyBusy | output | 1 | Ready/busy level, 0 while busy |

## Verification
The hardest situation to reach is a suspended erase in which both toggle bits already hold non-zero values. From there the bench must show that reads inside the erase blocks move bit 2 but not bit 6, and that resuming keeps both values instead of clearing them. The stimulus runs a block erase through its selection window and into its running phase with a chosen mix of hit and non-hit reads. This leaves a known toggle pattern. The bench then suspends, alternates hit and non-hit reads, and resumes. A chip erase is then failed with reads over failing and passing blocks, which exercises the sticky failure path and the fail-qualified bit 2.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

  typedef enum logic [2:0] {
    OP_READ    = 3'd0,
    OP_AUTOSEL = 3'd1,
    OP_PROG    = 3'd2,
    OP_CHIP    = 3'd3,
    OP_BLKWIN  = 3'd4,
    OP_BLKRUN  = 3'd5,
    OP_SUSP    = 3'd6,
    OP_RSVD    = 3'd7
  } opMode_e;

  // Status bit positions
  localparam int POS_POLL  = 7;
  localparam int POS_BUSYT = 6;
  localparam int POS_ERR   = 5;
  localparam int POS_PHASE = 3;
  localparam int POS_BLKT  = 2;

  // Strobes from the control part to the datapath part
  typedef struct packed {
    logic readDone;
    logic clrTog;
    logic togBusy;
    logic togBlock;
    logic showStatus;
    logic bit7Val;
    logic bit3Val;
    logic errOn;
  } statStrb_t;

endpackage

// File: rtl/fsr_ctrl.sv
module fsr_ctrl
  import fsr_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  opMode_e   mode,
  input  logic      rdStrobe,
  input  logic      blockHit,
  input  logic      blockFail,
  input  logic      progBit7,
  input  logic      opFail,
  input  logic      clrErr,
  output statStrb_t strb,
  output logic      rdyBusy
);

  logic    rdPrev;
  logic    hitHeld;
  logic    failHeld;
  opMode_e prevMode;
  logic    errFlag;
  logic    errErase;
  logic    errBit7;

  logic isProg;
  logic isErase;
  logic isBusy;
  logic isSusp;
  logic canFail;
  logic newOpEntry;

  always_comb begin
    isProg  = (mode == OP_PROG);
    isErase = (mode == OP_CHIP) || (mode == OP_BLKWIN) || (mode == OP_BLKRUN);
    isBusy  = isProg || isErase;
    isSusp  = (mode == OP_SUSP);
    canFail = isProg || (mode == OP_CHIP) || (mode == OP_BLKRUN);
    newOpEntry = (mode != prevMode) &&
                 ((mode == OP_PROG) || (mode == OP_CHIP) || (mode == OP_BLKWIN));
  end

  // Read-edge tracking and address qualification held over the read
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPrev   <= 1'b0;
      hitHeld  <= 1'b0;
      failHeld <= 1'b0;
      prevMode <= OP_READ;
    end else begin
      rdPrev   <= rdStrobe;
      prevMode <= mode;
      if (rdStrobe) begin
        hitHeld  <= blockHit;
        failHeld <= blockFail;
      end
    end
  end

  // Sticky failure record
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errFlag  <= 1'b0;
      errErase <= 1'b0;
      errBit7  <= 1'b0;
    end else if (clrErr) begin
      errFlag  <= 1'b0;
    end else if (opFail && canFail && !errFlag) begin
      errFlag  <= 1'b1;
      errErase <= !isProg;
      errBit7  <= progBit7;
    end
  end

  always_comb begin
    strb.readDone   = rdPrev && !rdStrobe;
    strb.clrTog     = newOpEntry;
    strb.togBusy    = errFlag || isBusy;
    if (errFlag)
      strb.togBlock = errErase && failHeld;
    else
      strb.togBlock = hitHeld && (isErase || isSusp);
    strb.showStatus = errFlag || isBusy || (isSusp && blockHit);
    if (errFlag)
      strb.bit7Val  = errErase ? 1'b0 : !errBit7;
    else if (isProg)
      strb.bit7Val  = !progBit7;
    else
      strb.bit7Val  = isSusp;
    if (errFlag)
      strb.bit3Val  = errErase;
    else
      strb.bit3Val  = (mode == OP_CHIP) || (mode == OP_BLKRUN);
    strb.errOn      = errFlag;
    rdyBusy         = !isBusy;
  end

  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    errFlag && !clrErr |=> errFlag); // R6

  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    clrErr |=> !errFlag); // R6

  AST_ERR_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> $past(opFail)); // R6

endmodule

// File: rtl/fsr_dpath.sv
module fsr_dpath
  import fsr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  statStrb_t         strb,
  input  logic [DATA_W-1:0] arrayData,
  output logic [DATA_W-1:0] statusOut
);

  logic tog6;
  logic tog2;
  logic [DATA_W-1:0] statWord;

  // Toggle flops: advance once per completed read, cleared on a new operation
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tog6 <= 1'b0;
      tog2 <= 1'b0;
    end else if (strb.clrTog) begin
      tog6 <= 1'b0;
      tog2 <= 1'b0;
    end else if (strb.readDone) begin
      if (strb.togBusy)  tog6 <= !tog6;
      if (strb.togBlock) tog2 <= !tog2;
    end
  end

  always_comb begin
    statWord            = '0;
    statWord[POS_POLL]  = strb.bit7Val;
    statWord[POS_BUSYT] = tog6;
    statWord[POS_ERR]   = strb.errOn;
    statWord[POS_PHASE] = strb.bit3Val;
    statWord[POS_BLKT]  = tog2;
    statusOut = strb.showStatus ? statWord : arrayData;
  end

  AST_BUSY_TOG_FLIP: assert property (@(posedge clk) disable iff (!rstN)
    strb.readDone && strb.togBusy && !strb.clrTog |=> tog6 != $past(tog6)); // R3

  AST_TOG_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !strb.readDone && !strb.clrTog |=> $stable(tog6) && $stable(tog2)); // R4

  AST_TOG_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrTog |=> !tog6 && !tog2); // R10

endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
  import fsr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        opState,
  input  logic              rdStrobe,
  input  logic              blockHit,
  input  logic              blockFail,
  input  logic              progBit7,
  input  logic              opFail,
  input  logic              clrErr,
  input  logic [DATA_W-1:0] arrayData,
  output logic [DATA_W-1:0] statusOut,
  output logic              rdyBusy
);

  opMode_e   mode;
  statStrb_t strb;

  assign mode = opMode_e'(opState);

  fsr_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .mode      (mode),
    .rdStrobe  (rdStrobe),
    .blockHit  (blockHit),
    .blockFail (blockFail),
    .progBit7  (progBit7),
    .opFail    (opFail),
    .clrErr    (clrErr),
    .strb      (strb),
    .rdyBusy   (rdyBusy)
  );

  fsr_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .arrayData (arrayData),
    .statusOut (statusOut)
  );

  AST_READY_IN_SUSPEND: assert property (@(posedge clk) disable iff (!rstN)
    (mode == OP_SUSP) |-> rdyBusy); // R9

endmodule

// File: tb/sim_flash_status_gen.sv
module sim_flash_status_gen;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] opState = 3'd0;
  logic       rdStrobe = 1'b0;
  logic       blockHit = 1'b0;
  logic       blockFail = 1'b0;
  logic       progBit7 = 1'b0;
  logic       opFail = 1'b0;
  logic       clrErr = 1'b0;
  logic [7:0] arrayData = 8'h5A;
  logic [7:0] statusOut;
  logic       rdyBusy;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_status_gen #(.DATA_W(8)) u0 (
    .clk(clk), .rstN(rstN), .opState(opState), .rdStrobe(rdStrobe),
    .blockHit(blockHit), .blockFail(blockFail), .progBit7(progBit7),
    .opFail(opFail), .clrErr(clrErr), .arrayData(arrayData),
    .statusOut(statusOut), .rdyBusy(rdyBusy)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic setOp(input logic [2:0] s);
    @(negedge clk); opState = s;
    @(negedge clk); #1;
  endtask

  task automatic pulseFail();
    @(negedge clk); opFail = 1'b1;
    @(negedge clk); opFail = 1'b0; #1;
  endtask

  task automatic pulseClr();
    @(negedge clk); clrErr = 1'b1;
    @(negedge clk); clrErr = 1'b0; #1;
  endtask

  // One read: word sampled while the strobe is high, flops advance after it drops
  task automatic rd(input logic hit, input logic fh, output logic [7:0] w);
    @(negedge clk); rdStrobe = 1'b1; blockHit = hit; blockFail = fh;
    @(negedge clk); #1; w = statusOut;
    rdStrobe = 1'b0;
    @(negedge clk); blockHit = 1'b0; blockFail = 1'b0; #1;
  endtask

  task automatic t_reset();
    chk("R1 passthrough", statusOut, 8'h5A);
    chk("R1 ready", {7'd0, rdyBusy}, 8'h01);
    setOp(3'd1); arrayData = 8'h01; #1;
    chk("R12 autoselect data", statusOut, 8'h01);
    chk("R9 autoselect ready", {7'd0, rdyBusy}, 8'h01);
  endtask

  task automatic t_program();
    logic [7:0] w;
    arrayData = 8'hFF; progBit7 = 1'b1;
    setOp(3'd2);
    chk("R9 program busy", {7'd0, rdyBusy}, 8'h00);
    rd(1'b0, 1'b0, w); chk("R2 R11 program first read", w, 8'h00);
    rd(1'b1, 1'b0, w); chk("R3 bit6 toggled", w, 8'h40);
    rd(1'b1, 1'b0, w); chk("R4 bit2 holds in program", w, 8'h00);
    progBit7 = 1'b0;
    rd(1'b0, 1'b0, w); chk("R2 inverted bit7", w, 8'hC0);
    setOp(3'd0);
    chk("R12 read after program", statusOut, 8'hFF);
  endtask

  task automatic t_blockErase();
    logic [7:0] w;
    arrayData = 8'h3C;
    setOp(3'd4);
    chk("R9 window busy", {7'd0, rdyBusy}, 8'h00);
    rd(1'b1, 1'b0, w); chk("R5 window bit3 0", w, 8'h00);
    rd(1'b0, 1'b0, w); chk("R4 bit2 toggled by hit", w, 8'h44);
    rd(1'b0, 1'b0, w); chk("R4 bit2 holds off-block", w, 8'h04);
    setOp(3'd5);
    rd(1'b1, 1'b0, w); chk("R10 R5 run keeps toggles", w, 8'h4C);
    rd(1'b1, 1'b0, w); chk("R3 R4 running", w, 8'h08);
    // now bit6=1 bit2=1
    setOp(3'd6);
    chk("R9 suspend ready", {7'd0, rdyBusy}, 8'h01);
    rd(1'b1, 1'b0, w); chk("R7 suspend hit", w, 8'hC4);
    rd(1'b1, 1'b0, w); chk("R7 bit6 static bit2 toggles", w, 8'hC0);
    rd(1'b0, 1'b0, w); chk("R7 suspend off-block data", w, 8'h3C);
    rd(1'b1, 1'b0, w); chk("R7 suspend hit again", w, 8'hC4);
    setOp(3'd5);
    rd(1'b1, 1'b0, w); chk("R10 resume keeps toggles", w, 8'h48);
    setOp(3'd0);
    chk("R12 read after erase", statusOut, 8'h3C);
  endtask

  task automatic t_chipFail();
    logic [7:0] w;
    // entering chip erase after tog2=1 left by previous run
    setOp(3'd3);
    rd(1'b1, 1'b0, w); chk("R10 chip clears toggles", w, 8'h08);
    rd(1'b1, 1'b0, w); chk("R5 chip bit3 1", w, 8'h4C);
    rd(1'b0, 1'b0, w); chk("R2 chip bit7 0", w, 8'h08);
    rd(1'b1, 1'b0, w); chk("R4 chip hit", w, 8'h48);
    pulseFail();
    setOp(3'd0);
    chk("R9 ready after fail", {7'd0, rdyBusy}, 8'h01);
    rd(1'b1, 1'b1, w); chk("R8 R12 fail status held", w, 8'h2C);
    rd(1'b1, 1'b0, w); chk("R8 bit2 holds good block", w, 8'h68);
    rd(1'b0, 1'b1, w); chk("R8 bit2 toggles bad block", w, 8'h28);
    rd(1'b0, 1'b0, w); chk("R6 sticky bit5", w, 8'h6C);
    pulseClr();
    chk("R6 cleared passthrough", statusOut, 8'h3C);
  endtask

  task automatic t_progFail();
    logic [7:0] w;
    arrayData = 8'h99;
    pulseFail();
    chk("R6 fail ignored in read", statusOut, 8'h99);
    progBit7 = 1'b1;
    setOp(3'd2);
    pulseFail();
    progBit7 = 1'b0;
    setOp(3'd0);
    rd(1'b0, 1'b0, w); chk("R8 program fail bit7 latched", w, 8'h20);
    rd(1'b1, 1'b0, w); chk("R8 R11 program fail toggles", w, 8'h60);
    pulseClr();
    chk("R6 clear after program fail", statusOut, 8'h99);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    t_reset();
    t_program();
    t_blockErase();
    t_chipFail();
    t_progFail();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule